// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives a single-cycle baud-rate strobe from a much faster system clock. It does not use an integer divide counter. It keeps a phase accumulator one bit wider than its working width. A constant step, fixed at elaboration time from the clock frequency and baud rate parameters, is added to the low bits of that accumulator. The carry out of the sum is the strobe. Because the step is a fraction of the full phase range, the average strobe rate tracks the requested baud rate to within the phase resolution, even when the clock is not an integer multiple of the baud rate.

The accumulator advances only while the transmitter reports it is busy. When the line is idle, the phase is frozen and no strobe is produced. A serial transmitter is expected to feed its busy flag in and shift one bit on each strobe.

The parameters must give a non-zero step. The baud rate must be at most half the clock frequency, so that two carries cannot occur back to back.

Top module: `baud_tick_gen`

## Requirements
- R1: A synchronous active-high `rst` clears all ACC_W+1 accumulator bits, so `tick` is 0 in the cycle after a reset edge. After release, the first carry comes on the ceil(2^ACC_W / STEP)-th busy edge.
- R2: STEP equals ((BAUD << (ACC_W−PRESCALE)) + (CLK_HZ >> (PRESCALE+1))) / (CLK_HZ >> PRESCALE), using integer division that rounds down. With CLK_HZ = 1 000 000, BAUD = 115 200, ACC_W = 16 and PRESCALE = 4, this gives 7550.
- R3: On each rising edge with `busy`=1 and `rst`=0, the ACC_W-bit phase becomes the low ACC_W bits of phase + STEP. `tick` is 1 in the following cycle exactly when that sum carried out of bit ACC_W−1.
- R4: On a rising edge with `busy`=0 and `rst`=0, the phase keeps its value and `tick` is 0 in the following cycle. When `busy` returns, accumulation resumes from the held phase.
- R5: `tick` is never 1 in two consecutive cycles.
- R6: Over N consecutive busy cycles that start from a cleared accumulator, the number of strobes is floor(N·STEP / 2^ACC_W). With the parameter values given in R2 and N = 20 000, this is 2304. That is within one of N·BAUD/CLK_HZ.
- R7: When `rst` and `busy` are both 1 on the same edge, reset wins and the accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | System clock |
| rst  | input  | 1 | Synchronous reset, active high |
| busy | input  | 1 | Transmitter busy; the phase advances only while this is 1 |
| tick | output | 1 | One-cycle baud strobe, the carry of the last phase addition |

## Verification
Two pairs of events can meet on a single edge. The first is a reset and an advancing busy edge. The second is a busy edge falling and the edge on which the phase would otherwise have carried. The bench provokes both:
- It asserts reset mid-run while `busy` stays high.
- It drops `busy` on the exact cycle that its own phase model predicts a carry.

A cycle-exact reference accumulator in the scoreboard judges each case. In the reset case, the strobe must not appear and the phase must restart from zero. In the idle case, the would-be carry must be suppressed, and the next strobe must come from the held phase once `busy` is raised again.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Rounded phase step for a carry-out accumulator of acc_w bits.
    // Both clock terms are pre-scaled by 'pre' to keep the product small.
    function automatic longint unsigned step_for(
        input longint unsigned clk_hz,
        input longint unsigned baud,
        input int unsigned     acc_w,
        input int unsigned     pre
    );
        longint unsigned num;
        longint unsigned den;
        den = clk_hz >> pre;
        num = (baud << (acc_w - pre)) + (clk_hz >> (pre + 1));
        return num / den;
    endfunction

endpackage

// File: rtl/baud_step_adder.sv
module baud_step_adder #(
    parameter int unsigned ACC_W = 16
) (
    input  logic [ACC_W-1:0] phase,
    input  logic [ACC_W-1:0] step,
    input  logic             advance,
    output logic [ACC_W:0]   next_acc
);
    // Carry bit is always recomputed: holding keeps the phase, drops the carry.
    always_comb begin
        if (advance)
            next_acc = {1'b0, phase} + {1'b0, step};
        else
            next_acc = {1'b0, phase};
    end
endmodule

// File: rtl/baud_phase_reg.sv
module baud_phase_reg #(
    parameter int unsigned ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic [ACC_W:0]   next_acc,
    output logic [ACC_W-1:0] phase,
    output logic             carry
);
    typedef struct packed {
        logic             carry;
        logic [ACC_W-1:0] phase;
    } acc_t;

    acc_t acc_q;

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_t'(next_acc);
    end

    assign phase = acc_q.phase;
    assign carry = acc_q.carry;

    // R1 / R7: a reset edge always leaves the whole accumulator cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc_q == '0));

    // R4: idle edges freeze the phase and produce no strobe
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(acc_q.phase) && !acc_q.carry));

    // R5: strobe never lasts two cycles
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        acc_q.carry |=> !acc_q.carry);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned BAUD     = 115_200,
    parameter int unsigned ACC_W    = 16,
    parameter int unsigned PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic tick
);
    localparam longint unsigned STEP_WIDE =
        baud_pkg::step_for(longint'(CLK_HZ), longint'(BAUD), ACC_W, PRESCALE);
    localparam logic [ACC_W-1:0] STEP = STEP_WIDE[ACC_W-1:0];
    localparam logic [ACC_W:0]   SPAN = {1'b1, {ACC_W{1'b0}}};

    logic [ACC_W-1:0] phase;
    logic [ACC_W:0]   next_acc;
    logic             carry;

    baud_step_adder #(.ACC_W(ACC_W)) u_adder (
        .phase    (phase),
        .step     (STEP),
        .advance  (busy),
        .next_acc (next_acc)
    );

    baud_phase_reg #(.ACC_W(ACC_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .next_acc (next_acc),
        .phase    (phase),
        .carry    (carry)
    );

    assign tick = carry;

    // R3: a busy edge strobes exactly when the old phase was within STEP of wrapping
    assert_carry_rule_R3: assert property (@(posedge clk) disable iff (rst)
        busy |=> (tick == ({1'b0, $past(phase)} >= (SPAN - {1'b0, STEP}))));
endmodule

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb;
    localparam int unsigned CLK_HZ = 1_000_000;
    localparam int unsigned BAUD   = 115_200;
    localparam longint unsigned EXP_STEP =
        ((longint'(BAUD) * 4096) + (CLK_HZ / 32)) / (CLK_HZ / 16);   // R2: 7550
    localparam int RATE_N = 20_000;

    logic clk  = 1'b0;
    logic rst  = 1'b1;
    logic busy = 1'b0;
    logic tick;

    always #2.5 clk = ~clk;

    baud_tick_gen #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ACC_W(16), .PRESCALE(4)) u_dut (
        .clk(clk), .rst(rst), .busy(busy), .tick(tick)
    );

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];
    int vectors = 0;
    int fails   = 0;
    int r6_ticks = 0;
    longint unsigned m_acc = 0;
    logic prev_tick = 1'b0;
    bit done = 1'b0;

    // driver: set inputs away from the edge, push the model's prediction
    task automatic drive(input logic r, input logic b, input string req);
        item_t it;
        @(negedge clk);
        rst  = r;
        busy = b;
        if (r)      m_acc = 0;
        else if (b) m_acc = (m_acc & 64'hFFFF) + EXP_STEP;
        else        m_acc = m_acc & 64'hFFFF;
        it.exp = m_acc[16];
        it.req = req;
        q.push_back(it);
    endtask

    // monitor: compare after the edge has settled
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                vectors++;
                if (tick !== it.exp) begin
                    fails++;
                    $display("FAIL %s: tick=%b expected=%b at %0t", it.req, tick, it.exp, $time);
                end
                vectors++;
                if (tick === 1'b1 && prev_tick === 1'b1) begin
                    fails++;
                    $display("FAIL R5: tick=1 expected=0 (two-cycle strobe) at %0t", $time);
                end
                if (it.req == "R6" && tick === 1'b1) r6_ticks++;
            end
            prev_tick = tick;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200_000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        longint unsigned exp_r6;
        // R1 / R7: reset held with busy high
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, "R1");
        // R2 / R3: first strobe on the 9th busy edge (ceil(65536/7550)), then steady run
        for (int i = 0; i < 30; i++) drive(1'b0, 1'b1, "R2");
        // R4: idle stretch, then resume from the held phase
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, "R4");
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b1, "R4");
        // R3: alternating busy pattern
        for (int i = 0; i < 40; i++) drive(1'b0, logic'(i % 2), "R3");
        // R4: drop busy on exactly the edge that would have carried
        for (int i = 0; i < 8; i++) begin
            if (((m_acc & 64'hFFFF) + EXP_STEP) >= 64'h10000) begin
                drive(1'b0, 1'b0, "R4");
                drive(1'b0, 1'b0, "R4");
            end
            drive(1'b0, 1'b1, "R4");
        end
        // R7: reset collides with busy mid-phase
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, "R7");
        drive(1'b1, 1'b1, "R7");
        for (int i = 0; i < 12; i++) drive(1'b0, 1'b1, "R7");
        // R6: long-window rate from a cleared accumulator
        drive(1'b1, 1'b0, "R1");
        for (int i = 0; i < RATE_N; i++) drive(1'b0, 1'b1, "R6");
        drive(1'b0, 1'b0, "R4");
        wait (q.size() == 0);
        @(negedge clk);
        exp_r6 = (longint'(RATE_N) * EXP_STEP) >> 16;
        vectors++;
        if (longint'(r6_ticks) != exp_r6) begin
            fails++;
            $display("FAIL R6: ticks=%0d expected=%0d", r6_ticks, exp_r6);
        end
        vectors++;
        if (r6_ticks > 2305 || r6_ticks < 2303) begin
            fails++;
            $display("FAIL R6: ticks=%0d expected=2304 +/-1 of ideal rate", r6_ticks);
        end
        finish_run();
    end
endmodule